// File: doc/BRIEF.md
# I/O Page Directory Translator

This block converts DMA addresses issued by a 32-bit PCI-side master into addresses on a 40-bit system bus. The conversion works on 4 KB pages. A window check uses a base register, a mask register and a range-enable flag to decide which path an access takes. Accesses inside an enabled window read a 64-bit entry from a page directory held in memory, through a simple request/response read port. All other accesses use a fixed absolute-to-physical mapping. In that mapping, a 32-bit address is sorted into the memory, I/O or firmware region by its high nibbles.

The block handles one translation at a time. A request is accepted with a valid/ready handshake. The result is reported with a one-cycle `done` pulse, together with the page-aligned input address, the physical page, a permission code and a fault flag. The control is a four-state machine:
- `ST_IDLE`: ready for a request. It moves to `ST_DONE` on a bypass accept, or to `ST_ISSUE` on a directory accept.
- `ST_ISSUE`: presents the directory read. It moves to `ST_WAIT` when the memory raises ready.
- `ST_WAIT`: waits for the entry. It moves to `ST_DONE` on the memory response.
- `ST_DONE`: presents the result. It returns to `ST_IDLE` unconditionally.

Top module: `iopd_xlate`

## Requirements
- R1: Out of reset, `req_ready` is 1 and both `done` and `mem_req_valid` are 0.
- R2: Every result reports `res_iova` equal to the request address with bits 11:0 cleared, and `res_page_mask` equal to 0xFFF. Two addresses in the same 4 KB page give identical results.
- R3: When bit 0 of `cfg_win_base` is 0, the access takes the bypass mapping and no directory read is issued.
- R4: When bit 0 of `cfg_win_base` is 1, the access uses the directory exactly when (page address AND `cfg_win_mask`) equals `cfg_win_base` with bit 0 cleared. The read address is then `cfg_dir_base` + (address >> 12) * 8. Otherwise the access bypasses, even for firmware-region addresses.
- R5: A directory entry with bit 63 set yields `res_phys` = entry with bit 63 and bits 11:0 cleared, `res_perm` = 2'b11 (read/write) and `fault` = 0.
- R6: A directory entry with bit 63 clear yields `fault` = 1, `res_perm` = 2'b00 (no access) and `res_phys` = 0.
- R7: On bypass, a page address with any of bits 63:32 set passes through unchanged, with perm 2'b11.
- R8: On bypass, a 32-bit address whose bits 31:28 are not 0xF is zero-extended (memory region).
- R9: On bypass, a 32-bit address with bits 31:28 = 0xF and bits 27:24 nonzero is sign-extended from bit 31 (I/O region).
- R10: On bypass, a 32-bit address with bits 31:24 = 0xF0 keeps bits 23:0 and has bits 63:36 set to one (firmware region).
- R11: Only one translation is in flight. `req_ready` drops in the cycle after an accept and stays low until `done`. `done` is a single-cycle pulse. A bypass result is on `done` in the cycle after the accept.
- R12: `mem_req_valid` holds with a stable address until `mem_req_ready`. The result appears on `done` in the cycle after `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_base | input | 64 | Window base; bit 0 is the range enable |
| cfg_win_mask | input | 64 | Window compare mask |
| cfg_dir_base | input | 64 | Byte address of the page directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | DMA address to translate |
| mem_req_valid | output | 1 | Directory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the directory entry |
| mem_rsp_valid | input | 1 | Directory entry returned |
| mem_rsp_data | input | 64 | Directory entry |
| done | output | 1 | Result valid, one cycle |
| fault | output | 1 | Entry invalid, no access |
| res_iova | output | 64 | Page-aligned input address |
| res_phys | output | 64 | Physical page address |
| res_perm | output | 2 | 2'b11 read/write, 2'b00 none |
| res_page_mask | output | 12 | Page offset mask, 0xFFF |

## Verification
A bypass result is due exactly one cycle after the accepting edge. A directory result is due one cycle after the edge that samples `mem_rsp_valid`. The directory read itself appears in the cycle after the accept. The bench drives and samples on falling edges. The driver checks `done` in the first falling edge after a bypass accept. The memory model checks `done` in the first falling edge after it drops its response. The scoreboard monitor pops the predicted result whenever `done` is seen, so a late, early or extra result surfaces as a mismatch or an empty-queue error. The memory model adds ready delays and response latencies of zero to several cycles, to show that the timing is set by the handshake alone.

// File: rtl/iopd_pkg.sv
package iopd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } xl_state_e;

    localparam logic [1:0] PERM_NONE = 2'b00;
    localparam logic [1:0] PERM_RW   = 2'b11;

endpackage

// File: rtl/iopd_window.sv
// Decides whether a page goes through the directory and forms the entry address.
module iopd_window #(
    parameter int ADDR_W  = 64,
    parameter int PAGE_SH = 12,
    parameter int SLOT_SH = 3
) (
    input  logic [ADDR_W-1:0] page_addr,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_mask,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              use_dir,
    output logic [ADDR_W-1:0] ent_addr
);
    logic [ADDR_W-1:0] base_cmp;
    logic              range_en;

    always_comb begin
        range_en = win_base[0];
        base_cmp = {win_base[ADDR_W-1:1], 1'b0};
        use_dir  = range_en && ((page_addr & win_mask) == base_cmp);
        ent_addr = dir_base + ((page_addr >> PAGE_SH) << SLOT_SH);
    end
endmodule

// File: rtl/iopd_absmap.sv
// Fixed absolute-to-physical mapping used on the bypass path.
module iopd_absmap #(
    parameter int ADDR_W = 64,
    parameter int PCI_W  = 32,
    parameter int PA_W   = 40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] phys
);
    localparam int FW_LOW = PCI_W - 8;
    localparam logic [ADDR_W-1:0] FW_FILL = {ADDR_W{1'b1}} << (PA_W - 4);

    logic       wide;
    logic [3:0] top_nib;
    logic [3:0] sub_nib;

    always_comb begin
        wide    = |addr[ADDR_W-1:PCI_W];
        top_nib = addr[PCI_W-1 -: 4];
        sub_nib = addr[PCI_W-5 -: 4];
        if (wide) begin
            phys = addr;
        end else if (top_nib != 4'hF) begin
            phys = {{(ADDR_W-PCI_W){1'b0}}, addr[PCI_W-1:0]};
        end else if (sub_nib != 4'h0) begin
            phys = {{(ADDR_W-PCI_W){addr[PCI_W-1]}}, addr[PCI_W-1:0]};
        end else begin
            phys = FW_FILL | {{(ADDR_W-FW_LOW){1'b0}}, addr[FW_LOW-1:0]};
        end
    end
endmodule

// File: rtl/iopd_entry_dec.sv
// Checks the valid bit of a directory entry and extracts the physical page.
module iopd_entry_dec #(
    parameter int ADDR_W  = 64,
    parameter int PAGE_SH = 12
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              ok,
    output logic [ADDR_W-1:0] page
);
    localparam int VALID_BIT = ADDR_W - 1;

    logic [ADDR_W-1:0] cleared;

    always_comb begin
        ok                 = entry[VALID_BIT];
        cleared            = entry;
        cleared[VALID_BIT] = 1'b0;
        page               = cleared & ({ADDR_W{1'b1}} << PAGE_SH);
    end
endmodule

// File: rtl/iopd_xlate.sv
module iopd_xlate
    import iopd_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int PCI_W   = 32,
    parameter int PA_W    = 40,
    parameter int PAGE_SH = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_win_base,
    input  logic [ADDR_W-1:0]  cfg_win_mask,
    input  logic [ADDR_W-1:0]  cfg_dir_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ADDR_W-1:0]  mem_rsp_data,
    output logic               done,
    output logic               fault,
    output logic [ADDR_W-1:0]  res_iova,
    output logic [ADDR_W-1:0]  res_phys,
    output logic [1:0]         res_perm,
    output logic [PAGE_SH-1:0] res_page_mask
);
    localparam int SLOT_SH = $clog2(ADDR_W / 8);
    localparam logic [ADDR_W-1:0] PAGE_KEEP = {ADDR_W{1'b1}} << PAGE_SH;

    xl_state_e state_q, state_d;

    logic [ADDR_W-1:0] req_page;
    logic              hit_dir;
    logic [ADDR_W-1:0] hit_ent_addr;
    logic [ADDR_W-1:0] bypass_phys;
    logic              ent_ok;
    logic [ADDR_W-1:0] ent_page;

    logic [ADDR_W-1:0] iova_q;
    logic [ADDR_W-1:0] ent_addr_q;
    logic [ADDR_W-1:0] phys_q;
    logic              fault_q;
    logic [1:0]        perm_q;

    logic accept;
    logic rsp_take;

    assign req_page = req_addr & PAGE_KEEP;

    iopd_window #(
        .ADDR_W (ADDR_W),
        .PAGE_SH(PAGE_SH),
        .SLOT_SH(SLOT_SH)
    ) u_window (
        .page_addr(req_page),
        .win_base (cfg_win_base),
        .win_mask (cfg_win_mask),
        .dir_base (cfg_dir_base),
        .use_dir  (hit_dir),
        .ent_addr (hit_ent_addr)
    );

    iopd_absmap #(
        .ADDR_W(ADDR_W),
        .PCI_W (PCI_W),
        .PA_W  (PA_W)
    ) u_absmap (
        .addr(req_page),
        .phys(bypass_phys)
    );

    iopd_entry_dec #(
        .ADDR_W (ADDR_W),
        .PAGE_SH(PAGE_SH)
    ) u_entry (
        .entry(mem_rsp_data),
        .ok   (ent_ok),
        .page (ent_page)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = hit_dir ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign rsp_take = (state_q == ST_WAIT) && mem_rsp_valid;

    // Result and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iova_q     <= '0;
            ent_addr_q <= '0;
            phys_q     <= '0;
            fault_q    <= 1'b0;
            perm_q     <= PERM_NONE;
        end else if (accept) begin
            iova_q     <= req_page;
            ent_addr_q <= hit_ent_addr;
            if (!hit_dir) begin
                phys_q  <= bypass_phys;
                fault_q <= 1'b0;
                perm_q  <= PERM_RW;
            end
        end else if (rsp_take) begin
            phys_q  <= ent_ok ? ent_page : '0;
            fault_q <= !ent_ok;
            perm_q  <= ent_ok ? PERM_RW : PERM_NONE;
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        done          = (state_q == ST_DONE);
        mem_req_addr  = ent_addr_q;
        fault         = fault_q;
        res_iova      = iova_q;
        res_phys      = phys_q;
        res_perm      = perm_q;
        res_page_mask = {PAGE_SH{1'b1}};
    end
endmodule

// File: rtl/iopd_xlate_chk.sv
module iopd_xlate_chk #(
    parameter int ADDR_W  = 64,
    parameter int PAGE_SH = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  cfg_win_base,
    input logic [ADDR_W-1:0]  cfg_win_mask,
    input logic [ADDR_W-1:0]  cfg_dir_base,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic               mem_rsp_valid,
    input logic [ADDR_W-1:0]  mem_rsp_data,
    input logic               done,
    input logic               fault,
    input logic [ADDR_W-1:0]  res_iova,
    input logic [ADDR_W-1:0]  res_phys,
    input logic [1:0]         res_perm,
    input logic [PAGE_SH-1:0] res_page_mask
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready && !done);

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

    // R12
    rsp_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && !req_ready && !mem_req_valid && !done) |=> done);

    // R3
    disabled_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_win_base[0]) |=> !mem_req_valid);

    // R6
    fault_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> res_perm == 2'b00 && res_phys == '0);

    // R5
    ok_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> res_perm == 2'b11 && res_phys[PAGE_SH-1:0] == '0);

    // R2
    iova_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_iova[PAGE_SH-1:0] == '0 && (&res_page_mask));
endmodule

bind iopd_xlate iopd_xlate_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_SH(PAGE_SH)
) u_chk (.*);

// File: tb/sim_iopd_xlate.sv
`timescale 1ns/1ps
module sim_iopd_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cfg_win_base = '0;
    logic [63:0] cfg_win_mask = '0;
    logic [63:0] cfg_dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic [63:0] res_iova;
    logic [63:0] res_phys;
    logic [1:0]  res_perm;
    logic [11:0] res_page_mask;

    always #4 clk = ~clk;

    iopd_xlate u0 (.*);

    typedef struct {
        logic [63:0] iova;
        logic [63:0] phys;
        logic        flt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [63:0] tb_entry;
    logic [63:0] tb_exp_maddr;
    bit          tb_exp_lookup;
    bit          tb_saw_req;
    int          tb_rdly;
    int          tb_lat;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Reference behaviour written from the requirements
    task automatic model(input logic [63:0] a, input logic [63:0] base, input logic [63:0] mask,
                         input logic [63:0] dbase, input logic [63:0] entry,
                         output bit lk, output logic [63:0] maddr,
                         output logic [63:0] ph, output logic flt);
        logic [63:0] pg;
        pg    = a & ~64'hFFF;
        lk    = base[0] && ((pg & mask) == (base & ~64'h1));
        maddr = dbase + (pg >> 12) * 8;
        flt   = 1'b0;
        if (lk) begin
            flt = !entry[63];
            ph  = flt ? 64'h0 : (entry & 64'h7FFF_FFFF_FFFF_F000);
        end else if (pg[63:32] != 0) begin
            ph = pg;
        end else if (pg[31:28] != 4'hF) begin
            ph = {32'h0, pg[31:0]};
        end else if (pg[27:24] != 4'h0) begin
            ph = {{32{pg[31]}}, pg[31:0]};
        end else begin
            ph = 64'hFFFF_FFF0_0000_0000 | {40'h0, pg[23:0]};
        end
    endtask

    // Driver: predicts, pushes to the scoreboard and issues one request
    task automatic run(input logic [63:0] a, input logic [63:0] base, input logic [63:0] mask,
                       input logic [63:0] dbase, input logic [63:0] entry,
                       input int rdly, input int lat, input string tag);
        exp_t e;
        bit lk;
        logic [63:0] maddr, ph;
        logic flt;
        model(a, base, mask, dbase, entry, lk, maddr, ph, flt);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_win_base  = base;
        cfg_win_mask  = mask;
        cfg_dir_base  = dbase;
        tb_entry      = entry;
        tb_rdly       = rdly;
        tb_lat        = lat;
        tb_exp_maddr  = maddr;
        tb_exp_lookup = lk;
        tb_saw_req    = 1'b0;
        e.iova = a & ~64'hFFF;
        e.phys = ph;
        e.flt  = flt;
        e.tag  = tag;
        exp_q.push_back(e);
        req_addr  = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11 busy after accept", {63'h0, req_ready}, 64'h0);
        if (!lk) chk(done, "R11 bypass done next cycle", {63'h0, done}, 64'h1);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(tb_saw_req == lk, lk ? "R4 directory read issued" : "R3 no directory read on bypass",
            {63'h0, tb_saw_req}, {63'h0, lk});
    endtask

    // Memory model for the directory read port
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                tb_saw_req = 1'b1;
                chk(tb_exp_lookup, "R4 unexpected directory read", mem_req_addr, 64'h0);
                chk(mem_req_addr == tb_exp_maddr, "R4 entry address", mem_req_addr, tb_exp_maddr);
                chk(!req_ready, "R11 busy while reading", {63'h0, req_ready}, 64'h0);
                repeat (tb_rdly) @(negedge clk);
                chk(mem_req_valid && mem_req_addr == tb_exp_maddr, "R12 request held",
                    mem_req_addr, tb_exp_maddr);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (tb_lat) @(negedge clk);
                mem_rsp_data  = tb_entry;
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 64'hDEAD_BEEF_0BAD_F00D;
                chk(done, "R12 done one cycle after response", {63'h0, done}, 64'h1);
            end
        end
    end

    // Monitor: pops the scoreboard whenever a result is presented
    initial begin
        forever begin
            @(negedge clk);
            if (done && rst_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected result", res_phys, 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(res_phys == e.phys, {e.tag, " phys"}, res_phys, e.phys);
                    chk(fault == e.flt && res_perm == (e.flt ? 2'b00 : 2'b11),
                        {e.tag, (e.flt ? " R6" : " R5"), " fault/perm"},
                        {61'h0, fault, res_perm}, {61'h0, e.flt, (e.flt ? 2'b00 : 2'b11)});
                    chk(res_iova == e.iova && res_page_mask == 12'hFFF, "R2 iova and page mask",
                        res_iova, e.iova);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finish");
        report();
    end

    localparam logic [63:0] DIR = 64'h0000_0001_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !mem_req_valid, "R1 state during reset",
            {61'h0, req_ready, done, mem_req_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !mem_req_valid, "R1 state after reset",
            {61'h0, req_ready, done, mem_req_valid}, 64'h4);

        // Bypass regions, range disabled
        run(64'h0000_0000_1234_5678, 64'h0, 64'h0, DIR, 64'h0, 0, 0, "R8 memory region");
        run(64'h0000_0000_F100_0ABC, 64'h0, 64'h0, DIR, 64'h0, 0, 0, "R9 io region");
        run(64'h0000_0000_F000_1234, 64'h0, 64'h0, DIR, 64'h0, 0, 0, "R10 firmware region");
        run(64'h0000_0012_3456_7890, 64'h0, 64'h0, DIR, 64'h0, 0, 0, "R7 wide passthrough");
        run(64'h0000_0000_7FFF_FFFF, 64'h0, 64'h0, DIR, 64'h0, 0, 0, "R8 memory top");
        run(64'h0000_0000_FFFF_F000, 64'h0, 64'h0, DIR, 64'h0, 0, 0, "R9 io top");

        // Window matches but range enable is clear
        run(64'h0000_0000_8000_5000, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_F000_0000,
            DIR, 64'h8000_0000_1111_1000, 0, 0, "R3 range disabled");
        // Enabled, outside window
        run(64'h0000_0000_9000_1000, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_F000_0000,
            DIR, 64'h8000_0000_1111_1000, 0, 0, "R4 outside window");
        // Enabled, inside window, valid entries with varied timing
        run(64'h0000_0000_8000_3ABC, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_F000_0000,
            DIR, 64'h8000_00AB_CDEF_0123, 0, 0, "R5 lookup fast");
        run(64'h0000_0000_8000_3001, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_F000_0000,
            DIR, 64'h8000_00AB_CDEF_0123, 2, 1, "R2 same page other offset");
        run(64'h0000_0000_8ABC_D000, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_F000_0000,
            DIR, 64'hFFFF_FFFF_FFFF_FFFF, 3, 5, "R5 lookup slow all ones");
        // Invalid entry
        run(64'h0000_0000_8000_7000, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_F000_0000,
            DIR, 64'h7FFF_0012_3456_7000, 1, 2, "R6 invalid entry");
        // Window over a firmware-region page: directory wins
        run(64'h0000_0000_F000_2FFF, 64'h0000_0000_F000_2001, 64'hFFFF_FFFF_FFFF_F000,
            64'h0000_0000_0020_0000, 64'h8000_0040_0000_5000, 0, 3, "R4 window over firmware");
        // Neighbouring page misses the exact window
        run(64'h0000_0000_F000_3000, 64'h0000_0000_F000_2001, 64'hFFFF_FFFF_FFFF_F000,
            64'h0000_0000_0020_0000, 64'h8000_0040_0000_5000, 0, 0, "R10 neighbour bypass");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all results delivered", exp_q.size(), 64'h0);
        chk(req_ready && !done && !mem_req_valid, "R11 idle at end",
            {61'h0, req_ready, done, mem_req_valid}, 64'h4);
        report();
    end
endmodule